// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block turns the digital indications of a set of supply detectors into one clean, deterministic system reset. A fixed brownout detector on the main supply, a supervisor on the regulated core supply, a firmware brownout request and other reset requests all feed it. It decides when the core regulator may be switched on and when the system may leave reset. It also decides when the I/O pads may leave their safe state.

Resets come in three levels. A main-supply brownout, or a firmware brownout request, restarts the whole power-up order with the regulator switched off. A low core supply or an external reset request holds the system in reset while the regulator stays on. A watchdog timeout or an illegal-instruction event gives only a short CPU-and-peripheral clear, without touching the reset pin or the pads. Five states set the order: off, regulator start, core wait, release and run. A release counter sets the minimum reset width.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `main_bod` is high, the outputs are `por_rst` = 1, `reg_en` = 0, `port_en` = 0 and `rst_pin_n` = 0, all without waiting for a clock edge.
- R2: `reg_en` rises on the first clock edge after `main_bod` falls and stays high until the next brownout. Core-supply faults are not evaluated before REG_SETTLE edges have passed in the regulator-start state.
- R3: Each of `core_low` and `ext_rst` passes through SYNC_STAGES flops. If either is high while the system runs, `por_rst` is high at the sample after the (SYNC_STAGES+1)-th edge. `reg_en` stays high during this.
- R4: With no fault present, `por_rst` falls REG_SETTLE+MIN_RST+2 edges after `main_bod` falls. While `core_low` or `ext_rst` stays high, `por_rst` stays high.
- R5: After the last fault input clears, `por_rst` falls exactly SYNC_STAGES+MIN_RST+1 edges later. A fault that comes back during the release count restarts the count.
- R6: `port_en` is low whenever `por_rst` is high. It rises one edge after `por_rst` falls.
- R7: A rising edge on `sw_bor_req` gives a full brownout-class restart. `por_rst` is high and `reg_en` low after the second edge, and `por_rst` falls REG_SETTLE+MIN_RST+4 edges after the first. Holding the request high gives only one restart.
- R8: A pulse on `wdt_tmo` or `illegal_op` while running holds `cpu_clr` high for exactly CLR_CYCLES samples. During this, `por_rst`, `rst_pin_n` and `port_en` do not change.
- R9: `cpu_clr` is high whenever `por_rst` is high.
- R10: `rst_pin_n` is 0 (pin driven low) exactly while `por_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| main_bod | input | 1 | Main-supply brownout detector, high = supply too low; asynchronous |
| core_low | input | 1 | Core-supply supervisor, high = core voltage too low |
| ext_rst | input | 1 | Other reset sources, high = reset requested |
| sw_bor_req | input | 1 | Firmware brownout request strobe, acts on its rising edge |
| wdt_tmo | input | 1 | Watchdog timeout pulse |
| illegal_op | input | 1 | Illegal-instruction pulse |
| reg_en | output | 1 | Core regulator enable |
| por_rst | output | 1 | Power-on / brownout system reset, active high |
| cpu_clr | output | 1 | CPU and peripheral clear, active high |
| rst_pin_n | output | 1 | External reset pin drive, low = pulled low |
| port_en | output | 1 | I/O pad enable, low = pads in safe state |

## Verification
Every output is a fixed number of edges away from its cause. The regulator enable comes one edge after the brownout ends. A fault in the running state shows up SYNC_STAGES+1 edges after it is driven. Reset release comes SYNC_STAGES+MIN_RST+1 edges after the last fault clears, or REG_SETTLE+MIN_RST+2 edges after power-up. The pad enable follows one edge after release, and a watchdog clear lasts CLR_CYCLES samples. The bench drives inputs on the falling clock edge and samples 2 ns after each rising edge. It counts edges from the drive and compares the count with the expected latency, which bench functions derive from the parameters. Brownout effects are checked right after the drive, because they do not wait for a clock edge.

// File: rtl/pwr_rst_seq_pkg.sv
package pwr_rst_seq_pkg;

   typedef enum logic [2:0] {
      SEQ_OFF       = 3'd0,
      SEQ_REG_START = 3'd1,
      SEQ_CORE_WAIT = 3'd2,
      SEQ_RELEASE   = 3'd3,
      SEQ_RUN       = 3'd4
   } seq_state_t;

   function automatic int unsigned cnt_bits(input int unsigned max_val);
      int unsigned b;
      b = 1;
      while ((1 << b) <= max_val) b++;
      return b;
   endfunction

endpackage

// File: rtl/prs_sync.sv
module prs_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES == 0) begin : g_bypass
      assign dout = din;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or posedge arst) begin
            if (arst) begin
               stg[i] <= {WIDTH{RST_VAL}};
            end else begin
               if (i == 0) stg[i] <= din;
               else        stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
         end
      end
      assign dout = stg[STAGES-1];
   end

endmodule

// File: rtl/prs_oneshot.sv
module prs_oneshot (
   input  logic clk,
   input  logic arst,
   input  logic req,
   output logic hit
);

   logic req_q;
   logic req_qq;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         req_q  <= 1'b0;
         req_qq <= 1'b0;
      end else begin
         req_q  <= req;
         req_qq <= req_q;
      end
   end

   assign hit = req_q & ~req_qq;

endmodule

// File: rtl/prs_clr_stretch.sv
module prs_clr_stretch #(
   parameter int unsigned CLR_CYCLES = 4
) (
   input  logic clk,
   input  logic arst,
   input  logic trig,
   output logic active
);

   localparam int unsigned CW = pwr_rst_seq_pkg::cnt_bits(CLR_CYCLES);

   logic [CW-1:0] left;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         left <= '0;
      end else if (trig) begin
         left <= CW'(CLR_CYCLES);
      end else if (left != '0) begin
         left <= left - 1'b1;
      end
   end

   assign active = (left != '0);

endmodule

// File: rtl/prs_fsm.sv
module prs_fsm
   import pwr_rst_seq_pkg::*;
#(
   parameter int unsigned REG_SETTLE = 4,
   parameter int unsigned MIN_RST    = 8
) (
   input  logic clk,
   input  logic arst,
   input  logic sw_hit,
   input  logic fault,
   output logic reg_on,
   output logic run_now,
   output logic run_next
);

   localparam int unsigned CMAX = (REG_SETTLE > MIN_RST) ? REG_SETTLE : MIN_RST;
   localparam int unsigned CW   = cnt_bits(CMAX);

   seq_state_t    st, st_nxt;
   logic [CW-1:0] cnt, cnt_nxt;

   always_comb begin
      st_nxt  = st;
      cnt_nxt = cnt;
      if (sw_hit) begin
         st_nxt  = SEQ_OFF;
         cnt_nxt = '0;
      end else begin
         unique case (st)
            SEQ_OFF: begin
               st_nxt  = SEQ_REG_START;
               cnt_nxt = '0;
            end
            SEQ_REG_START: begin
               if (cnt == CW'(REG_SETTLE - 1)) begin
                  st_nxt  = SEQ_CORE_WAIT;
                  cnt_nxt = '0;
               end else begin
                  cnt_nxt = cnt + 1'b1;
               end
            end
            SEQ_CORE_WAIT: begin
               if (!fault) begin
                  st_nxt  = SEQ_RELEASE;
                  cnt_nxt = '0;
               end
            end
            SEQ_RELEASE: begin
               if (fault) begin
                  st_nxt  = SEQ_CORE_WAIT;
                  cnt_nxt = '0;
               end else if (cnt == CW'(MIN_RST - 1)) begin
                  st_nxt  = SEQ_RUN;
                  cnt_nxt = '0;
               end else begin
                  cnt_nxt = cnt + 1'b1;
               end
            end
            SEQ_RUN: begin
               if (fault) st_nxt = SEQ_CORE_WAIT;
            end
            default: begin
               st_nxt  = SEQ_OFF;
               cnt_nxt = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         st  <= SEQ_OFF;
         cnt <= '0;
      end else begin
         st  <= st_nxt;
         cnt <= cnt_nxt;
      end
   end

   assign reg_on   = (st != SEQ_OFF);
   assign run_now  = (st == SEQ_RUN);
   assign run_next = (st_nxt == SEQ_RUN);

endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REG_SETTLE  = 4,
   parameter int unsigned MIN_RST     = 8,
   parameter int unsigned CLR_CYCLES  = 4
) (
   input  logic clk,
   input  logic main_bod,
   input  logic core_low,
   input  logic ext_rst,
   input  logic sw_bor_req,
   input  logic wdt_tmo,
   input  logic illegal_op,
   output logic reg_en,
   output logic por_rst,
   output logic cpu_clr,
   output logic rst_pin_n,
   output logic port_en
);

   if (REG_SETTLE < 1) begin : g_bad_settle
      $error("REG_SETTLE must be at least 1");
   end
   if (MIN_RST < 1) begin : g_bad_min
      $error("MIN_RST must be at least 1");
   end
   if (CLR_CYCLES < 1) begin : g_bad_clr
      $error("CLR_CYCLES must be at least 1");
   end

   logic [1:0] flt_raw;
   logic [1:0] flt_sync;
   logic       flt_s;
   logic       sw_hit;
   logic       reg_on;
   logic       run_now;
   logic       run_next;
   logic       light_clr;
   logic       port_q;

   assign flt_raw = {ext_rst, core_low};

   prs_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk  (clk),
      .arst (main_bod),
      .din  (flt_raw),
      .dout (flt_sync)
   );

   assign flt_s = |flt_sync;

   prs_oneshot u_swbor (
      .clk  (clk),
      .arst (main_bod),
      .req  (sw_bor_req),
      .hit  (sw_hit)
   );

   prs_fsm #(
      .REG_SETTLE (REG_SETTLE),
      .MIN_RST    (MIN_RST)
   ) u_fsm (
      .clk      (clk),
      .arst     (main_bod),
      .sw_hit   (sw_hit),
      .fault    (flt_s),
      .reg_on   (reg_on),
      .run_now  (run_now),
      .run_next (run_next)
   );

   prs_clr_stretch #(
      .CLR_CYCLES (CLR_CYCLES)
   ) u_clr (
      .clk    (clk),
      .arst   (main_bod),
      .trig   (wdt_tmo | illegal_op),
      .active (light_clr)
   );

   always_ff @(posedge clk or posedge main_bod) begin
      if (main_bod) port_q <= 1'b0;
      else          port_q <= run_now & run_next;
   end

   assign reg_en    = reg_on;
   assign por_rst   = ~run_now;
   assign rst_pin_n = run_now;
   assign cpu_clr   = ~run_now | light_clr;
   assign port_en   = port_q;

endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk #(
   parameter int unsigned MIN_RST = 8
) (
   input logic clk,
   input logic main_bod,
   input logic sw_bor_req,
   input logic wdt_tmo,
   input logic illegal_op,
   input logic flt_s,
   input logic reg_en,
   input logic por_rst,
   input logic cpu_clr,
   input logic port_en
);

   localparam int unsigned QW = pwr_rst_seq_pkg::cnt_bits(MIN_RST + 1);

   logic [QW-1:0] clean_cnt;

   always_ff @(posedge clk or posedge main_bod) begin
      if (main_bod) begin
         clean_cnt <= '0;
      end else if (!por_rst || flt_s) begin
         clean_cnt <= '0;
      end else if (clean_cnt != QW'(MIN_RST + 1)) begin
         clean_cnt <= clean_cnt + 1'b1;
      end
   end

   p_bod_hold_r1: assert property (@(posedge clk)
      main_bod |-> (!reg_en && !port_en && por_rst));

   p_reg_before_release_r2: assert property (@(posedge clk) disable iff (main_bod)
      !reg_en |-> por_rst);

   p_fault_resets_r3: assert property (@(posedge clk) disable iff (main_bod)
      flt_s |=> por_rst);

   p_min_width_r5: assert property (@(posedge clk) disable iff (main_bod)
      $fell(por_rst) |-> (clean_cnt >= QW'(MIN_RST)));

   p_port_hold_r6: assert property (@(posedge clk) disable iff (main_bod)
      port_en |-> (!por_rst && $past(!por_rst)));

   p_sw_bor_r7: assert property (@(posedge clk) disable iff (main_bod)
      $rose(sw_bor_req) |=> ##1 (por_rst && !reg_en));

   p_light_clr_r8: assert property (@(posedge clk) disable iff (main_bod)
      (wdt_tmo || illegal_op) |=> cpu_clr);

endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(
   .MIN_RST (MIN_RST)
) u_chk (
   .clk        (clk),
   .main_bod   (main_bod),
   .sw_bor_req (sw_bor_req),
   .wdt_tmo    (wdt_tmo),
   .illegal_op (illegal_op),
   .flt_s      (flt_s),
   .reg_en     (reg_en),
   .por_rst    (por_rst),
   .cpu_clr    (cpu_clr),
   .port_en    (port_en)
);

// File: tb/pwr_rst_seq_test.sv
`timescale 1ns/1ps
module pwr_rst_seq_test;

   localparam int SYNC = 2;
   localparam int RS   = 4;
   localparam int MINR = 8;
   localparam int CLRC = 4;

   logic clk = 1'b0;
   logic main_bod, core_low, ext_rst, sw_bor_req, wdt_tmo, illegal_op;
   logic reg_en, por_rst, cpu_clr, rst_pin_n, port_en;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   pwr_rst_seq #(
      .SYNC_STAGES (SYNC),
      .REG_SETTLE  (RS),
      .MIN_RST     (MINR),
      .CLR_CYCLES  (CLRC)
   ) uut (
      .clk        (clk),
      .main_bod   (main_bod),
      .core_low   (core_low),
      .ext_rst    (ext_rst),
      .sw_bor_req (sw_bor_req),
      .wdt_tmo    (wdt_tmo),
      .illegal_op (illegal_op),
      .reg_en     (reg_en),
      .por_rst    (por_rst),
      .cpu_clr    (cpu_clr),
      .rst_pin_n  (rst_pin_n),
      .port_en    (port_en)
   );

   function automatic int lat_powerup();    return RS + MINR + 2;   endfunction
   function automatic int lat_fault_clear(); return SYNC + MINR + 1; endfunction
   function automatic int lat_fault_hit();  return SYNC + 1;        endfunction
   function automatic int lat_swbor();      return RS + MINR + 4;   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   // counts edges from the last drive until por_rst falls, returns the count
   task automatic wait_release(output int n);
      n = 0;
      do begin
         tick();
         n++;
         chk(rst_pin_n == ~por_rst, "R10 pin tracks reset", rst_pin_n, ~por_rst);
         chk(!por_rst || cpu_clr, "R9 clear during reset", cpu_clr, 1);
      end while (por_rst && n < 200);
   endtask

   task automatic check_port_follow();
      chk(port_en == 1'b0, "R6 pads held at release edge", port_en, 0);
      tick();
      chk(port_en == 1'b1, "R6 pads enabled one edge later", port_en, 1);
   endtask

   task automatic fault_pulse(input bit use_ext, input int len);
      int n;
      @(negedge clk);
      if (use_ext) ext_rst = 1'b1; else core_low = 1'b1;
      for (int i = 1; i <= len; i++) begin
         tick();
         if (i == lat_fault_hit()) begin
            chk(por_rst == 1'b1, "R3 fault asserts reset", por_rst, 1);
            chk(reg_en == 1'b1, "R3 regulator stays on", reg_en, 1);
            chk(port_en == 1'b0, "R6 pads drop with reset", port_en, 0);
         end
      end
      @(negedge clk);
      ext_rst  = 1'b0;
      core_low = 1'b0;
      wait_release(n);
      chk(n == lat_fault_clear(), "R5 release after last fault", n, lat_fault_clear());
      check_port_follow();
   endtask

   task automatic light_pulse(input bit use_ill);
      int n;
      @(negedge clk);
      if (use_ill) illegal_op = 1'b1; else wdt_tmo = 1'b1;
      n = 0;
      tick();
      @(negedge clk);
      wdt_tmo    = 1'b0;
      illegal_op = 1'b0;
      while (cpu_clr && n < 50) begin
         n++;
         chk(por_rst == 1'b0 && rst_pin_n == 1'b1 && port_en == 1'b1,
             "R8 light clear leaves reset alone", {por_rst, rst_pin_n, port_en}, 3'b011);
         tick();
      end
      chk(n == CLRC, "R8 clear length", n, CLRC);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      void'($urandom(32'd4711));
      main_bod   = 1'b0;
      core_low   = 1'b0;
      ext_rst    = 1'b0;
      sw_bor_req = 1'b0;
      wdt_tmo    = 1'b0;
      illegal_op = 1'b0;
      #1 main_bod = 1'b1;
      repeat (5) tick();
      chk(por_rst == 1 && reg_en == 0 && port_en == 0 && rst_pin_n == 0,
          "R1 reset state", {por_rst, reg_en, port_en, rst_pin_n}, 4'b1000);

      // R2 R4: clean power-up
      @(negedge clk);
      main_bod = 1'b0;
      tick();
      chk(reg_en == 1'b1, "R2 regulator on first edge", reg_en, 1);
      n = 1;
      while (por_rst && n < 200) begin tick(); n++; end
      chk(n == lat_powerup(), "R4 power-up release latency", n, lat_powerup());
      check_port_follow();

      // R1: brownout while running acts without a clock
      @(negedge clk);
      main_bod = 1'b1;
      #2;
      chk(por_rst == 1 && reg_en == 0 && port_en == 0 && rst_pin_n == 0,
          "R1 brownout immediate", {por_rst, reg_en, port_en, rst_pin_n}, 4'b1000);

      // R4: power-up with core supply still low
      core_low = 1'b1;
      repeat (3) tick();
      @(negedge clk);
      main_bod = 1'b0;
      repeat (30) tick();
      chk(por_rst == 1'b1, "R4 held while core low", por_rst, 1);
      chk(reg_en == 1'b1, "R2 regulator on with core low", reg_en, 1);
      @(negedge clk);
      core_low = 1'b0;
      wait_release(n);
      chk(n == lat_fault_clear(), "R5 release after core good", n, lat_fault_clear());
      check_port_follow();

      // R5: fault returns inside the release count
      @(negedge clk);
      ext_rst = 1'b1;
      repeat (6) tick();
      @(negedge clk);
      ext_rst = 1'b0;
      repeat (4) tick();
      @(negedge clk);
      core_low = 1'b1;
      tick();
      @(negedge clk);
      core_low = 1'b0;
      wait_release(n);
      chk(n == lat_fault_clear(), "R5 restart on returning fault", n, lat_fault_clear());
      check_port_follow();

      // R7: firmware brownout held high
      @(negedge clk);
      sw_bor_req = 1'b1;
      tick();
      chk(por_rst == 1'b0, "R7 no reset after first edge", por_rst, 0);
      tick();
      chk(por_rst == 1 && reg_en == 0, "R7 full brownout", {por_rst, reg_en}, 2'b10);
      n = 2;
      while (por_rst && n < 200) begin tick(); n++; end
      chk(n == lat_swbor(), "R7 firmware brownout release", n, lat_swbor());
      check_port_follow();
      repeat (40) tick();
      chk(por_rst == 1'b0 && reg_en == 1'b1, "R7 held request gives one reset", por_rst, 0);
      @(negedge clk);
      sw_bor_req = 1'b0;
      repeat (5) tick();
      chk(por_rst == 1'b0, "R7 request release no effect", por_rst, 0);

      // R8 directed
      light_pulse(1'b0);
      light_pulse(1'b1);

      // random mix
      for (int k = 0; k < 24; k++) begin
         int kind;
         kind = int'($urandom % 3);
         if (kind == 0) light_pulse($urandom % 2 == 1);
         else fault_pulse(kind == 2, SYNC + 1 + int'($urandom % 5));
         repeat (int'($urandom % 4)) tick();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule